// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block controls how a small 16-bit processor enters an interrupt handler and how it comes back from one. When the current instruction finishes and an unmasked request is waiting, the sequencer captures the register snapshot and the return address, and signals the core to discard its prefetched instructions. It then writes a nine-byte frame below the stack pointer, one byte per memory handshake. Next it raises the mask bits in the condition-code value and loads the program counter from a two-byte vector table entry.

On a return-from-interrupt with no request waiting, the sequencer reads the frame back in ascending address order and hands every register to the core in a single restore cycle. If a request is already waiting when the return executes, the frame stays where it is. The sequencer then jumps straight to the waiting source's vector, so the core avoids a pointless pop and re-push. Choosing which source wins is left to an external priority block, which supplies the vector-table address.

Top module: `irq_seq`

## Requirements
- R1: A synchronous active-high `rst` puts the sequencer in idle, with `busy` and `mem_req` low. `ccr_val` reads 0x50, meaning the I bit (bit 4) and the X bit (bit 6) are set.
- R2: A request is taken only in a cycle where `insn_done` is high and `rti_req` is low. `irq_req` counts only when `ccr_in` bit 4 is 0, and `xirq_req` counts only when `ccr_in` bit 6 is 0.
- R3: After a request is taken, `queue_flush` pulses for exactly one cycle before the first memory request. The return address stacked is `pc_in` as sampled in the accepting cycle.
- R4: Entry performs nine writes at addresses SP-1 down to SP-9, where SP is `sp_in` at acceptance. The bytes written are, in order: PC low, PC high, Y low, Y high, X low, X high, D low, D high, CCR. Each 16-bit value therefore has its high byte at the lower address.
- R5: After the CCR byte is written, `ccr_load` and `sp_load` pulse together. `ccr_val` is `ccr_in` with bit 4 set, and bit 6 is also set if the accepted request came from `xirq_req`. `sp_val` is SP-9.
- R6: The handler address is read as the high byte at V and the low byte at V+1. V is `vec_addr` as sampled when the sequence began, and later changes to `vec_addr` are ignored. `pc_load` then pulses once with that word.
- R7: While `mem_req` is high and `mem_ack` is low, `mem_addr`, `mem_we` and `mem_wdata` hold steady. One byte moves per cycle in which both are high.
- R8: A return with no request pending reads SP..SP+8 in ascending order. It then pulses `ccr_load`, `regs_load`, `sp_load` (SP+9) and `pc_load` in the same cycle, carrying the restored values.
- R9: A return with `irq_req` or `xirq_req` high performs no stack access and no `sp_load`. It reads the vector straight away and loads the program counter from it.
- R10: `insn_done`, `rti_req` and requests arriving while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_done | input | 1 | Current instruction completes this cycle |
| rti_req | input | 1 | Completing instruction is a return-from-interrupt |
| irq_req | input | 1 | Maskable request pending |
| xirq_req | input | 1 | Non-maskable-class request pending |
| vec_addr | input | 16 | Vector-table location of the winning source |
| pc_in | input | 16 | Address of the next instruction |
| y_in | input | 16 | Y register snapshot |
| x_in | input | 16 | X register snapshot |
| d_in | input | 16 | Accumulator pair snapshot (high byte A) |
| ccr_in | input | 8 | Condition-code snapshot |
| sp_in | input | 16 | Stack pointer snapshot |
| busy | output | 1 | Sequence in progress |
| queue_flush | output | 1 | One-cycle pulse: discard prefetched instructions |
| mem_req | output | 1 | Memory byte request |
| mem_we | output | 1 | Write (1) or read (0) |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with `mem_ack` |
| mem_ack | input | 1 | Byte transfer completes this cycle |
| pc_load | output | 1 | Load program counter from `pc_val` |
| pc_val | output | 16 | New program counter |
| ccr_load | output | 1 | Load condition code from `ccr_val` |
| ccr_val | output | 8 | New condition code |
| sp_load | output | 1 | Load stack pointer from `sp_val` |
| sp_val | output | 16 | New stack pointer |
| regs_load | output | 1 | Load Y, X, D from restored values |
| y_val | output | 16 | Restored Y |
| x_val | output | 16 | Restored X |
| d_val | output | 16 | Restored D |

## Verification
The hardest case to create is a change to the inputs in the middle of a sequence. This covers a vector address that moves after acceptance and a second request that arrives while the frame is still being written. To reach it, the bench drives the first request and then alters `vec_addr` or pulses `insn_done` with a new request a few cycles later. The memory model acknowledges only every other cycle, so the sequence is still mid-frame when the disturbance lands. Both return paths are reached by preloading a frame in the memory model and by raising `rti_req` with and without a request pending.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_FLUSH, S_PUSH, S_MASK, S_VEC, S_POP, S_RESTORE
  } seq_state_t;

  localparam int CCR_W     = 8;
  localparam int CCR_I_BIT = 4;
  localparam int CCR_X_BIT = 6;
endpackage

// File: rtl/irq_accept.sv
module irq_accept
  import irq_seq_pkg::*;
(
  input  logic             idle,
  input  logic             insn_done,
  input  logic             rti_req,
  input  logic             irq_req,
  input  logic             xirq_req,
  input  logic [CCR_W-1:0] ccr_in,
  output logic             take_entry,
  output logic             take_xirq,
  output logic             rti_full,
  output logic             rti_bypass
);
  logic ok_x, ok_i, any_pend, at_end;

  always_comb begin
    ok_x       = xirq_req && !ccr_in[CCR_X_BIT];
    ok_i       = irq_req  && !ccr_in[CCR_I_BIT];
    any_pend   = irq_req || xirq_req;
    at_end     = idle && insn_done;
    take_entry = at_end && !rti_req && (ok_x || ok_i);
    take_xirq  = ok_x;
    rti_full   = at_end && rti_req && !any_pend;
    rti_bypass = at_end && rti_req && any_pend;
  end
endmodule

// File: rtl/irq_frame_pack.sv
module irq_frame_pack
  import irq_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int RW = 16,
  localparam int FB = (CCR_W + 3*RW + AW) / 8,
  localparam int KW = $clog2(FB)
) (
  input  logic [AW-1:0]    pc,
  input  logic [RW-1:0]    y,
  input  logic [RW-1:0]    x,
  input  logic [RW-1:0]    d,
  input  logic [CCR_W-1:0] ccr,
  input  logic [KW-1:0]    idx,
  output logic [7:0]       byte_o
);
  logic [FB*8-1:0] img;
  logic [7:0]      slot [FB];

  assign img = {ccr, d, x, y, pc};

  for (genvar g = 0; g < FB; g++) begin : g_slot
    assign slot[g] = img[g*8 +: 8];
  end

  always_comb begin
    byte_o = 8'h00;
    for (int i = 0; i < FB; i++)
      if (idx == KW'(i)) byte_o = slot[i];
  end
endmodule

// File: rtl/irq_frame_unpack.sv
module irq_frame_unpack
  import irq_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int RW = 16,
  localparam int FB = (CCR_W + 3*RW + AW) / 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic [7:0]       din,
  output logic [AW-1:0]    pc,
  output logic [RW-1:0]    y,
  output logic [RW-1:0]    x,
  output logic [RW-1:0]    d,
  output logic [CCR_W-1:0] ccr
);
  logic [FB*8-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst)           sh_q <= '0;
    else if (shift_en) sh_q <= {sh_q[FB*8-9:0], din};
  end

  assign pc  = sh_q[0 +: AW];
  assign y   = sh_q[AW +: RW];
  assign x   = sh_q[AW+RW +: RW];
  assign d   = sh_q[AW+2*RW +: RW];
  assign ccr = sh_q[AW+3*RW +: CCR_W];
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int RW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             insn_done,
  input  logic             rti_req,
  input  logic             irq_req,
  input  logic             xirq_req,
  input  logic [AW-1:0]    vec_addr,
  input  logic [AW-1:0]    pc_in,
  input  logic [RW-1:0]    y_in,
  input  logic [RW-1:0]    x_in,
  input  logic [RW-1:0]    d_in,
  input  logic [CCR_W-1:0] ccr_in,
  input  logic [AW-1:0]    sp_in,
  output logic             busy,
  output logic             queue_flush,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [7:0]       mem_wdata,
  input  logic [7:0]       mem_rdata,
  input  logic             mem_ack,
  output logic             pc_load,
  output logic [AW-1:0]    pc_val,
  output logic             ccr_load,
  output logic [CCR_W-1:0] ccr_val,
  output logic             sp_load,
  output logic [AW-1:0]    sp_val,
  output logic             regs_load,
  output logic [RW-1:0]    y_val,
  output logic [RW-1:0]    x_val,
  output logic [RW-1:0]    d_val
);
  localparam int FB     = (CCR_W + 3*RW + AW) / 8;
  localparam int KW     = $clog2(FB);
  localparam int VB     = AW / 8;
  localparam logic [KW-1:0] K_LAST = KW'(FB - 1);
  localparam logic [KW-1:0] V_LAST = KW'(VB - 1);
  localparam logic [CCR_W-1:0] I_MASK = CCR_W'(1) << CCR_I_BIT;
  localparam logic [CCR_W-1:0] X_MASK = CCR_W'(1) << CCR_X_BIT;

  seq_state_t       state_q;
  logic [KW-1:0]    k_q;
  logic [AW-1:0]    sp_q, vec_q, vword_q, addr_q;
  logic [AW-1:0]    pc_q;
  logic [RW-1:0]    y_q, x_q, d_q;
  logic [CCR_W-1:0] ccr_q;
  logic             xsel_q, req_q, we_q;

  logic take_entry, take_xirq, rti_full, rti_bypass, xfer;
  logic [AW-1:0]    u_pc;
  logic [RW-1:0]    u_y, u_x, u_d;
  logic [CCR_W-1:0] u_ccr;

  assign xfer = req_q && mem_ack;

  irq_accept u_acc (
    .idle(state_q == S_IDLE), .insn_done(insn_done), .rti_req(rti_req),
    .irq_req(irq_req), .xirq_req(xirq_req), .ccr_in(ccr_in),
    .take_entry(take_entry), .take_xirq(take_xirq),
    .rti_full(rti_full), .rti_bypass(rti_bypass)
  );

  irq_frame_pack #(.AW(AW), .RW(RW)) u_pack (
    .pc(pc_q), .y(y_q), .x(x_q), .d(d_q), .ccr(ccr_q),
    .idx(k_q), .byte_o(mem_wdata)
  );

  irq_frame_unpack #(.AW(AW), .RW(RW)) u_unpack (
    .clk(clk), .rst(rst), .shift_en(state_q == S_POP && xfer),
    .din(mem_rdata), .pc(u_pc), .y(u_y), .x(u_x), .d(u_d), .ccr(u_ccr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= S_IDLE;
      k_q         <= '0;
      sp_q        <= '0;
      vec_q       <= '0;
      vword_q     <= '0;
      addr_q      <= '0;
      pc_q        <= '0;
      y_q         <= '0;
      x_q         <= '0;
      d_q         <= '0;
      ccr_q       <= '0;
      xsel_q      <= 1'b0;
      req_q       <= 1'b0;
      we_q        <= 1'b0;
      queue_flush <= 1'b0;
      pc_load     <= 1'b0;
      pc_val      <= '0;
      ccr_load    <= 1'b0;
      ccr_val     <= I_MASK | X_MASK;
      sp_load     <= 1'b0;
      sp_val      <= '0;
      regs_load   <= 1'b0;
      y_val       <= '0;
      x_val       <= '0;
      d_val       <= '0;
    end else begin
      queue_flush <= 1'b0;
      pc_load     <= 1'b0;
      ccr_load    <= 1'b0;
      sp_load     <= 1'b0;
      regs_load   <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (rti_full) begin
            state_q <= S_POP;
            sp_q    <= sp_in;
            addr_q  <= sp_in;
            k_q     <= '0;
            req_q   <= 1'b1;
            we_q    <= 1'b0;
          end else if (rti_bypass) begin
            state_q     <= S_VEC;
            queue_flush <= 1'b1;
            vec_q       <= vec_addr;
            addr_q      <= vec_addr;
            k_q         <= '0;
            req_q       <= 1'b1;
            we_q        <= 1'b0;
          end else if (take_entry) begin
            state_q     <= S_FLUSH;
            queue_flush <= 1'b1;
            pc_q        <= pc_in;
            y_q         <= y_in;
            x_q         <= x_in;
            d_q         <= d_in;
            ccr_q       <= ccr_in;
            sp_q        <= sp_in;
            vec_q       <= vec_addr;
            xsel_q      <= take_xirq;
          end
        end
        S_FLUSH: begin
          state_q <= S_PUSH;
          addr_q  <= sp_q - AW'(1);
          k_q     <= '0;
          req_q   <= 1'b1;
          we_q    <= 1'b1;
        end
        S_PUSH: begin
          if (xfer) begin
            if (k_q == K_LAST) begin
              req_q   <= 1'b0;
              state_q <= S_MASK;
            end else begin
              k_q    <= k_q + KW'(1);
              addr_q <= addr_q - AW'(1);
            end
          end
        end
        S_MASK: begin
          ccr_load <= 1'b1;
          ccr_val  <= ccr_q | I_MASK | (xsel_q ? X_MASK : '0);
          sp_load  <= 1'b1;
          sp_val   <= sp_q - AW'(FB);
          state_q  <= S_VEC;
          addr_q   <= vec_q;
          k_q      <= '0;
          req_q    <= 1'b1;
          we_q     <= 1'b0;
        end
        S_VEC: begin
          if (xfer) begin
            if (k_q == V_LAST) begin
              pc_val  <= {vword_q[AW-9:0], mem_rdata};
              pc_load <= 1'b1;
              req_q   <= 1'b0;
              state_q <= S_IDLE;
            end else begin
              vword_q <= {vword_q[AW-9:0], mem_rdata};
              k_q     <= k_q + KW'(1);
              addr_q  <= addr_q + AW'(1);
            end
          end
        end
        S_POP: begin
          if (xfer) begin
            if (k_q == K_LAST) begin
              req_q   <= 1'b0;
              state_q <= S_RESTORE;
            end else begin
              k_q    <= k_q + KW'(1);
              addr_q <= addr_q + AW'(1);
            end
          end
        end
        S_RESTORE: begin
          ccr_load  <= 1'b1;
          ccr_val   <= u_ccr;
          regs_load <= 1'b1;
          y_val     <= u_y;
          x_val     <= u_x;
          d_val     <= u_d;
          sp_load   <= 1'b1;
          sp_val    <= sp_q + AW'(FB);
          pc_load   <= 1'b1;
          pc_val    <= u_pc;
          state_q   <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy     = (state_q != S_IDLE);
  assign mem_req  = req_q;
  assign mem_we   = we_q;
  assign mem_addr = addr_q;
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk
  import irq_seq_pkg::*;
#(
  parameter int AW = 16
) (
  input logic             clk,
  input logic             rst,
  input seq_state_t       state,
  input logic             mem_req,
  input logic             mem_ack,
  input logic             mem_we,
  input logic [AW-1:0]    mem_addr,
  input logic [7:0]       mem_wdata,
  input logic             queue_flush,
  input logic             pc_load,
  input logic             ccr_load,
  input logic [CCR_W-1:0] ccr_val
);
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (state == S_IDLE && !mem_req)); // R1
  AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE) |-> !mem_req); // R10
  AST_FLUSH_BEFORE_PUSH: assert property (@(posedge clk) disable iff (rst)
    (state == S_FLUSH && queue_flush) |=> (mem_req && mem_we)); // R3
  AST_MASK_SETS_I: assert property (@(posedge clk) disable iff (rst)
    (state == S_MASK) |=> (ccr_load && ccr_val[CCR_I_BIT])); // R5
  AST_PC_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    pc_load |=> !pc_load); // R6
  AST_HOLD_CTRL: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R7
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && !mem_ack) |=> $stable(mem_wdata)); // R7
endmodule

bind irq_seq irq_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .state(state_q), .mem_req(mem_req),
  .mem_ack(mem_ack), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .queue_flush(queue_flush), .pc_load(pc_load),
  .ccr_load(ccr_load), .ccr_val(ccr_val)
);

// File: tb/tb_irq_seq.sv
`timescale 1ns/1ps
module tb_irq_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic insn_done = 0, rti_req = 0, irq_req = 0, xirq_req = 0;
  logic [15:0] vec_addr = 0, pc_in = 0, y_in = 0, x_in = 0, d_in = 0, sp_in = 0;
  logic [7:0]  ccr_in = 0;
  logic busy, queue_flush, mem_req, mem_we, mem_ack;
  logic [15:0] mem_addr, pc_val, sp_val, y_val, x_val, d_val;
  logic [7:0]  mem_wdata, mem_rdata, ccr_val;
  logic pc_load, ccr_load, sp_load, regs_load;

  always #2.5 clk = ~clk;

  irq_seq dut (
    .clk(clk), .rst(rst), .insn_done(insn_done), .rti_req(rti_req),
    .irq_req(irq_req), .xirq_req(xirq_req), .vec_addr(vec_addr),
    .pc_in(pc_in), .y_in(y_in), .x_in(x_in), .d_in(d_in), .ccr_in(ccr_in),
    .sp_in(sp_in), .busy(busy), .queue_flush(queue_flush),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .pc_load(pc_load), .pc_val(pc_val), .ccr_load(ccr_load),
    .ccr_val(ccr_val), .sp_load(sp_load), .sp_val(sp_val),
    .regs_load(regs_load), .y_val(y_val), .x_val(x_val), .d_val(d_val)
  );

  // memory model: 256 bytes, optional every-other-cycle stall
  logic [7:0] mem [256];
  logic stall_en = 0, ph = 0;
  assign mem_ack   = mem_req && !(stall_en && ph);
  assign mem_rdata = mem[mem_addr[7:0]];

  // monitor
  logic log_clr = 0;
  int   n_wr, n_rd, n_flush, n_pc, n_ccr, n_sp, n_regs;
  logic early_req;
  logic [15:0] wr_log [16];
  logic [15:0] g_pc, g_sp, g_y, g_x, g_d;
  logic [7:0]  g_ccr;

  always @(posedge clk) begin
    ph <= ~ph;
    if (mem_req && mem_we && mem_ack) mem[mem_addr[7:0]] <= mem_wdata;
    if (log_clr) begin
      n_wr <= 0; n_rd <= 0; n_flush <= 0; n_pc <= 0; n_ccr <= 0;
      n_sp <= 0; n_regs <= 0; early_req <= 1'b0;
    end else begin
      if (mem_req && mem_ack && mem_we) begin
        if (n_wr < 16) wr_log[n_wr] <= mem_addr;
        n_wr <= n_wr + 1;
      end
      if (mem_req && mem_ack && !mem_we) n_rd <= n_rd + 1;
      if (queue_flush) n_flush <= n_flush + 1;
      if (mem_req && mem_we && n_flush == 0) early_req <= 1'b1;
      if (pc_load)   begin n_pc <= n_pc + 1; g_pc <= pc_val; end
      if (ccr_load)  begin n_ccr <= n_ccr + 1; g_ccr <= ccr_val; end
      if (sp_load)   begin n_sp <= n_sp + 1; g_sp <= sp_val; end
      if (regs_load) begin n_regs <= n_regs + 1; g_y <= y_val; g_x <= x_val; g_d <= d_val; end
    end
  end

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
    end
  endtask

  task automatic clr_log();
    @(negedge clk); log_clr = 1;
    @(negedge clk); log_clr = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while (busy && n < 400) begin @(negedge clk); n++; end
    if (n >= 400) chk(0, "watchdog", 32'(busy), 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_done();
    insn_done = 1;
    @(negedge clk);
    insn_done = 0; rti_req = 0; irq_req = 0; xirq_req = 0;
  endtask

  task automatic set_snap(input logic [15:0] sp);
    pc_in = 16'h1234; y_in = 16'h5678; x_in = 16'h9ABC; d_in = 16'hDEF0; sp_in = sp;
  endtask

  task automatic t_reset();
    chk(busy == 0, "R1 busy", 32'(busy), 0);
    chk(mem_req == 0, "R1 mem_req", 32'(mem_req), 0);
    chk(ccr_val == 8'h50, "R1 ccr_val", 32'(ccr_val), 32'h50);
  endtask

  task automatic t_masked();
    clr_log();
    set_snap(16'h0080); ccr_in = 8'h10; irq_req = 1; vec_addr = 16'h00F0;
    pulse_done();
    wait_idle();
    chk(n_wr == 0 && n_pc == 0, "R2 masked irq ignored", 32'(n_wr), 0);
    ccr_in = 8'h00; irq_req = 1;           // unmasked but no insn_done
    repeat (4) @(negedge clk);
    chk(busy == 0, "R2 waits for insn_done", 32'(busy), 0);
    irq_req = 0;
    wait_idle();
    chk(n_wr == 0 && n_flush == 0, "R2 no entry without insn_done", 32'(n_wr), 0);
  endtask

  task automatic check_frame(input logic [15:0] sp, input logic [7:0] ccr, input string rq);
    logic [7:0] ex [9];
    ex = '{pc_in[7:0], pc_in[15:8], y_in[7:0], y_in[15:8], x_in[7:0], x_in[15:8],
           d_in[7:0], d_in[15:8], ccr};
    for (int i = 0; i < 9; i++) begin
      chk(mem[8'(sp - 16'(i + 1))] == ex[i], rq, 32'(mem[8'(sp - 16'(i + 1))]), 32'(ex[i]));
      chk(wr_log[i] == sp - 16'(i + 1), "R4 write order", 32'(wr_log[i]), 32'(sp - 16'(i + 1)));
    end
  endtask

  task automatic t_entry_irq();
    clr_log();
    stall_en = 1;
    mem[8'hF0] = 8'hAB; mem[8'hF1] = 8'hCD;
    set_snap(16'h0080); ccr_in = 8'h00; irq_req = 1; vec_addr = 16'h00F0;
    pulse_done();
    wait_idle();
    chk(n_flush == 1, "R3 one flush pulse", 32'(n_flush), 1);
    chk(!early_req, "R3 flush precedes stacking", 32'(early_req), 0);
    chk(n_wr == 9, "R4 nine writes", 32'(n_wr), 9);
    check_frame(16'h0080, 8'h00, "R4 frame byte");
    chk(g_ccr == 8'h10, "R5 I set, X clear", 32'(g_ccr), 32'h10);
    chk(g_sp == 16'h0077, "R5 sp minus 9", 32'(g_sp), 32'h77);
    chk(n_pc == 1 && g_pc == 16'hABCD, "R6 vector word", 32'(g_pc), 32'hABCD);
    chk(n_rd == 2, "R7 two vector reads under stalls", 32'(n_rd), 2);
    stall_en = 0;
  endtask

  task automatic t_entry_xirq();
    clr_log();
    stall_en = 1;
    mem[8'hF2] = 8'h12; mem[8'hF3] = 8'h34;
    set_snap(16'h00A0); ccr_in = 8'h10; xirq_req = 1; vec_addr = 16'h00F2;
    pulse_done();
    @(negedge clk); vec_addr = 16'h00F0;     // later change must not matter
    @(negedge clk);
    insn_done = 1; irq_req = 1; ccr_in = 8'h00;   // second request while busy
    @(negedge clk);
    insn_done = 0; irq_req = 0;
    wait_idle();
    chk(g_ccr == 8'h50, "R5 X set for xirq", 32'(g_ccr), 32'h50);
    chk(g_pc == 16'h1234, "R6 vector latched at start", 32'(g_pc), 32'h1234);
    chk(n_pc == 1 && n_wr == 9, "R10 request during busy ignored", 32'(n_pc), 1);
    check_frame(16'h00A0, 8'h10, "R7 frame byte under stalls");
    stall_en = 0;
  endtask

  task automatic t_rti_full();
    logic [7:0] fr [9];
    fr = '{8'h05, 8'hDD, 8'h11, 8'hAA, 8'h22, 8'hBB, 8'h33, 8'h9A, 8'hBC};
    for (int i = 0; i < 9; i++) mem[8'h40 + 8'(i)] = fr[i];
    clr_log();
    sp_in = 16'h0040; rti_req = 1;
    pulse_done();
    wait_idle();
    chk(n_wr == 0 && n_rd == 9, "R8 nine reads, no writes", 32'(n_rd), 9);
    chk(g_ccr == 8'h05, "R8 ccr", 32'(g_ccr), 32'h05);
    chk(g_d == 16'hDD11 && n_regs == 1, "R8 d", 32'(g_d), 32'hDD11);
    chk(g_x == 16'hAA22, "R8 x", 32'(g_x), 32'hAA22);
    chk(g_y == 16'hBB33, "R8 y", 32'(g_y), 32'hBB33);
    chk(g_pc == 16'h9ABC, "R8 pc", 32'(g_pc), 32'h9ABC);
    chk(g_sp == 16'h0049, "R8 sp plus 9", 32'(g_sp), 32'h49);
  endtask

  task automatic t_rti_bypass();
    clr_log();
    mem[8'hF0] = 8'hAB; mem[8'hF1] = 8'hCD;
    sp_in = 16'h0040; ccr_in = 8'h10; rti_req = 1; irq_req = 1; vec_addr = 16'h00F0;
    pulse_done();
    wait_idle();
    chk(n_wr == 0 && n_rd == 2, "R9 only vector reads", 32'(n_rd), 2);
    chk(n_sp == 0 && n_regs == 0, "R9 no sp or register load", 32'(n_sp), 0);
    chk(n_pc == 1 && g_pc == 16'hABCD, "R9 pending vector", 32'(g_pc), 32'hABCD);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_masked();
    t_entry_irq();
    t_entry_xirq();
    t_rti_full();
    t_rti_bypass();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule